// File: doc/BRIEF.md
# Channel-Switch Result Valid Sequencer

This block sits beside a shared sigma-delta style converter that can sample either a voltage input or a temperature input, and decides at every conversion-complete strobe which channel the next conversion uses and whether the result that just finished may be trusted. A plain channel change blanks results while the digital filter settles. A fast-temperature sequence slips one temperature conversion into a voltage stream without any blanking, provided the software keeps to a read-and-clear handshake.

A separate flag marks the always-sampled current channel, which is set by every conversion no matter which voltage/temperature channel is active. All flags are cleared by the data-read strobe, so software sees exactly which results are fresh since its last read.

Top module: `chsw_valid_seq`

## Requirements
- R1: After reset `chan_sel_o` is 0 (voltage), all three valid flags are low and `proto_err_o` is low.
- R2: Channel encoding is 0 = voltage, 1 = temperature for both `chan_req_i` and `chan_sel_o`. A `conv_done_i` pulse on a settled channel raises that channel's valid flag on the following clock.
- R3: With no fast sequence in progress, a `conv_done_i` pulse while `chan_req_i` differs from `chan_sel_o` moves `chan_sel_o` to the requested channel; that pulse's result still belongs to the old channel. The first two conversions on the new channel are not flagged and the third is.
- R4: A channel change that occurs while the settling window is still running restarts the full three-conversion window.
- R5: `cur_valid_o` rises on the clock after every `conv_done_i` pulse, on either channel and in every mode.
- R6: `data_rd_i` clears all three valid flags; when `conv_done_i` and `data_rd_i` coincide, the flags that the conversion sets end high.
- R7: When `fast_req_i` is high at a `conv_done_i` pulse on a settled voltage channel with no fast sequence active, the next conversion is still voltage and is flagged, the one after it is temperature, and then sampling returns to voltage with no blanked results.
- R8: The temperature result of a fast sequence is flagged only if `data_rd_i` pulsed after the voltage conversion that preceded it had completed and before the temperature conversion completed; otherwise no temperature flag is raised.
- R9: From acceptance of a fast request until its temperature result, `chan_req_i` has no effect on `chan_sel_o`.
- R10: After a fast temperature result, each `conv_done_i` pulse seen while `fast_req_i` is still high raises `proto_err_o` for one clock and starts no new fast sequence; once `fast_req_i` has been low for a clock, a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done_i | input | 1 | One-clock strobe at the end of each conversion |
| chan_req_i | input | 1 | Requested channel for normal switching (0 voltage, 1 temperature) |
| fast_req_i | input | 1 | Fast-temperature request bit, held by software |
| data_rd_i | input | 1 | One-clock strobe when software reads the result |
| chan_sel_o | output | 1 | Channel used by the conversion now running |
| volt_valid_o | output | 1 | Fresh settled voltage result available |
| temp_valid_o | output | 1 | Fresh settled temperature result available |
| cur_valid_o | output | 1 | Fresh current-channel result available |
| proto_err_o | output | 1 | One-clock pulse on a fast-request handshake violation |

## Verification
The hardest state to reach is a fast sequence that ends with the request bit still set, because it needs an accepted request, a temperature conversion with and without the intervening read, and then further conversions before software clears the bit. The stimulus walks there deliberately: it first settles the voltage channel, runs one clean fast sequence, runs a second with the read left out, keeps the bit high for two more conversions to show that no third sequence starts, then drops the bit for one clock and shows a fresh request is accepted. A switch issued in the middle of a settling window is driven separately to show that the count restarts rather than continues.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ARMED = 2'd1,
        FS_TEMP  = 2'd2,
        FS_DONE  = 2'd3
    } fast_state_e;

    typedef enum logic {
        CH_VOLT = 1'b0,
        CH_TEMP = 1'b1
    } chan_e;

    localparam int FLAG_VOLT = 0;
    localparam int FLAG_TEMP = 1;
    localparam int FLAG_CUR  = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/chsw_fast_ctrl.sv
module chsw_fast_ctrl
    import chsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic fast_req,
    input  logic data_rd,
    input  logic volt_settled,
    output logic hold_chan,
    output logic steer_temp,
    output logic temp_phase,
    output logic temp_ok,
    output logic proto_err
);

    typedef struct packed {
        fast_state_e state;
        logic        rd_seen;
        logic        err;
    } fast_regs_t;

    fast_regs_t fr_d, fr_q;
    logic       accept;

    always_comb begin
        fr_d   = fr_q;
        fr_d.err = 1'b0;
        accept = 1'b0;
        unique case (fr_q.state)
            FS_IDLE: begin
                if (conv_done && fast_req && volt_settled) begin
                    accept     = 1'b1;
                    fr_d.state = FS_ARMED;
                end
            end
            FS_ARMED: begin
                if (conv_done) begin
                    fr_d.state   = FS_TEMP;
                    fr_d.rd_seen = 1'b0;
                end
            end
            FS_TEMP: begin
                if (data_rd && !conv_done) begin
                    fr_d.rd_seen = 1'b1;
                end
                if (conv_done) begin
                    fr_d.state = FS_DONE;
                end
            end
            FS_DONE: begin
                if (!fast_req) begin
                    fr_d.state = FS_IDLE;
                end else if (conv_done) begin
                    fr_d.err = 1'b1;
                end
            end
            default: fr_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{state: FS_IDLE, rd_seen: 1'b0, err: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign hold_chan  = (fr_q.state != FS_IDLE) || accept;
    assign steer_temp = (fr_q.state == FS_ARMED);
    assign temp_phase = (fr_q.state == FS_TEMP);
    assign temp_ok    = fr_q.rd_seen;
    assign proto_err  = fr_q.err;

    // R10: an error pulse only follows a completed fast sequence
    assert_err_from_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.err |-> $past(fr_q.state == FS_DONE));

    // R10: no new sequence while the request bit was left high
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == FS_DONE && fast_req) |=> (fr_q.state != FS_ARMED));

endmodule

// File: rtl/chsw_chan_ctrl.sv
module chsw_chan_ctrl
    import chsw_pkg::*;
#(
    parameter int SETTLE_CONV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic chan_req,
    input  logic hold_chan,
    input  logic steer_temp,
    input  logic temp_phase,
    output logic chan_sel,
    output logic volt_settled,
    output logic result_ok
);

    localparam int CW = $clog2(SETTLE_CONV + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CONV);

    typedef struct packed {
        chan_e         chan;
        logic [CW-1:0] settle;
    } chan_regs_t;

    chan_regs_t cr_d, cr_q;
    chan_e      req_chan;

    assign req_chan = chan_e'(chan_req);

    always_comb begin
        cr_d = cr_q;
        if (conv_done) begin
            if (cr_q.settle != '0) begin
                cr_d.settle = cr_q.settle - CW'(1);
            end
            if (temp_phase) begin
                cr_d.chan   = CH_VOLT;
                cr_d.settle = '0;
            end else if (steer_temp) begin
                cr_d.chan   = CH_TEMP;
                cr_d.settle = '0;
            end else if (!hold_chan && (req_chan != cr_q.chan)) begin
                cr_d.chan   = req_chan;
                cr_d.settle = RELOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q <= '{chan: CH_VOLT, settle: '0};
        end else begin
            cr_q <= cr_d;
        end
    end

    assign chan_sel     = cr_q.chan;
    assign volt_settled = (cr_q.chan == CH_VOLT) && (cr_q.settle == '0);
    assign result_ok    = (cr_q.settle <= CW'(1));

    // R3: channel and settling state only move on a conversion strobe
    assert_quiet_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> ($stable(cr_q.chan) && $stable(cr_q.settle)));

    // R7: the fast temperature slot hands back to a settled voltage channel
    assert_fast_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && temp_phase) |=> (cr_q.chan == CH_VOLT && cr_q.settle == '0));

endmodule

// File: rtl/chsw_flags.sv
module chsw_flags #(
    parameter int NFLAGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_i,
    input  logic              clr_i,
    output logic [NFLAGS-1:0] flag_o
);

    logic [NFLAGS-1:0] flag_d, flag_q;

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_comb begin
            flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else begin
                flag_q[g] <= flag_d[g];
            end
        end

        // R6: a read with no coinciding set empties the flag
        assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[g]) |=> !flag_q[g]);

        // R6: a set wins over a coinciding read
        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/chsw_valid_seq.sv
module chsw_valid_seq
    import chsw_pkg::*;
#(
    parameter int SETTLE_CONV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done_i,
    input  logic chan_req_i,
    input  logic fast_req_i,
    input  logic data_rd_i,
    output logic chan_sel_o,
    output logic volt_valid_o,
    output logic temp_valid_o,
    output logic cur_valid_o,
    output logic proto_err_o
);

    logic hold_chan, steer_temp, temp_phase, temp_ok;
    logic chan_sel, volt_settled, result_ok;
    logic [NUM_FLAGS-1:0] flag_set, flags;

    chsw_fast_ctrl u_fast (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done_i),
        .fast_req     (fast_req_i),
        .data_rd      (data_rd_i),
        .volt_settled (volt_settled),
        .hold_chan    (hold_chan),
        .steer_temp   (steer_temp),
        .temp_phase   (temp_phase),
        .temp_ok      (temp_ok),
        .proto_err    (proto_err_o)
    );

    chsw_chan_ctrl #(.SETTLE_CONV(SETTLE_CONV)) u_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done    (conv_done_i),
        .chan_req     (chan_req_i),
        .hold_chan    (hold_chan),
        .steer_temp   (steer_temp),
        .temp_phase   (temp_phase),
        .chan_sel     (chan_sel),
        .volt_settled (volt_settled),
        .result_ok    (result_ok)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_VOLT] = conv_done_i && result_ok && (chan_sel == CH_VOLT);
        flag_set[FLAG_TEMP] = conv_done_i && result_ok && (chan_sel == CH_TEMP)
                              && (!temp_phase || temp_ok);
        flag_set[FLAG_CUR]  = conv_done_i;
    end

    chsw_flags #(.NFLAGS(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (data_rd_i),
        .flag_o (flags)
    );

    assign chan_sel_o   = chan_sel;
    assign volt_valid_o = flags[FLAG_VOLT];
    assign temp_valid_o = flags[FLAG_TEMP];
    assign cur_valid_o  = flags[FLAG_CUR];

    // R5: every conversion marks the current channel fresh
    assert_cur_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i |=> cur_valid_o);

    // R8: an unread fast slot leaves the temperature flag untouched except by a read
    assert_temp_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && temp_phase && !temp_ok)
        |=> (temp_valid_o == ($past(temp_valid_o) && !$past(data_rd_i))));

endmodule

// File: tb/chsw_valid_seq_tb.sv
module chsw_valid_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_done = 1'b0, chan_req = 1'b0, fast_req = 1'b0, data_rd = 1'b0;
    logic chan_sel, v_valid, t_valid, c_valid, p_err;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        int    cyc;
        logic  v, t, c, ch, er;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    chsw_valid_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_done_i  (conv_done),
        .chan_req_i   (chan_req),
        .fast_req_i   (fast_req),
        .data_rd_i    (data_rd),
        .chan_sel_o   (chan_sel),
        .volt_valid_o (v_valid),
        .temp_valid_o (t_valid),
        .cur_valid_o  (c_valid),
        .proto_err_o  (p_err)
    );

    // monitor: compares outputs one edge after the stimulus was applied
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0 && sb[0].cyc < cyc) begin
            e = sb.pop_front();
            checks++;
            if ({v_valid, t_valid, c_valid, chan_sel, p_err} !== {e.v, e.t, e.c, e.ch, e.er}) begin
                fails++;
                $display("FAIL %s: got v=%0b t=%0b cur=%0b ch=%0b err=%0b, expected v=%0b t=%0b cur=%0b ch=%0b err=%0b",
                         e.tag, v_valid, t_valid, c_valid, chan_sel, p_err,
                         e.v, e.t, e.c, e.ch, e.er);
            end
        end
    end

    // driver: one clock per call, expected outputs after that clock
    task automatic s(input logic cd, input logic rd,
                     input logic v, input logic t, input logic c,
                     input logic ch, input logic er, input string tag);
        conv_done = cd;
        data_rd   = rd;
        sb.push_back('{cyc, v, t, c, ch, er, tag});
        @(negedge clk);
        conv_done = 1'b0;
        data_rd   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        s(0,0, 0,0,0,0,0, "R1 reset state");
        s(1,0, 1,0,1,0,0, "R2 voltage flagged");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        s(1,0, 1,0,1,0,0, "R2 voltage again");
        s(1,1, 1,0,1,0,0, "R6 set wins over read");
        s(0,1, 0,0,0,0,0, "R6 read clears");

        chan_req = 1'b1;
        s(1,0, 1,0,1,1,0, "R3 switch pulse keeps old channel result");
        s(0,1, 0,0,0,1,0, "R6 read clears");
        s(1,0, 0,0,1,1,0, "R3 first blanked");
        s(1,0, 0,0,1,1,0, "R3 second blanked");
        s(1,0, 0,1,1,1,0, "R3 third flagged");
        s(1,0, 0,1,1,1,0, "R2 temperature flagged");
        s(0,1, 0,0,0,1,0, "R6 read clears");

        chan_req = 1'b0;
        s(1,0, 0,1,1,0,0, "R3 switch back");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        chan_req = 1'b1;
        s(1,0, 0,0,1,1,0, "R4 switch during settling");
        s(1,0, 0,0,1,1,0, "R4 blanked after reload");
        s(1,0, 0,0,1,1,0, "R4 still blanked after reload");
        s(1,0, 0,1,1,1,0, "R4 flagged after full window");
        s(0,1, 0,0,0,1,0, "R6 read clears");

        chan_req = 1'b0;
        s(1,0, 0,1,1,0,0, "R3 switch to voltage");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        s(1,0, 0,0,1,0,0, "R5 current flag while blanked");
        s(1,0, 0,0,1,0,0, "R3 second blanked");
        s(1,0, 1,0,1,0,0, "R3 voltage settled");
        s(0,1, 0,0,0,0,0, "R6 read clears");

        fast_req = 1'b1;
        s(1,0, 1,0,1,0,0, "R7 request accepted");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        chan_req = 1'b1;
        s(1,0, 1,0,1,1,0, "R7 one voltage conversion then temperature");
        s(0,1, 0,0,0,1,0, "R8 voltage read");
        s(1,0, 0,1,1,0,0, "R8 R9 temperature flagged, back to voltage");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        chan_req = 1'b0;
        fast_req = 1'b0;
        s(0,0, 0,0,0,0,0, "R10 bit cleared");
        s(1,0, 1,0,1,0,0, "R7 voltage resumes without blanking");
        s(0,1, 0,0,0,0,0, "R6 read clears");

        fast_req = 1'b1;
        s(1,0, 1,0,1,0,0, "R7 second request accepted");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        s(1,0, 1,0,1,1,0, "R7 temperature next");
        s(1,0, 1,0,1,0,0, "R8 unread voltage blocks temperature flag");
        s(0,1, 0,0,0,0,0, "R6 read clears");

        s(1,0, 1,0,1,0,1, "R10 bit left high");
        s(0,0, 1,0,1,0,0, "R10 error is one clock");
        s(1,0, 1,0,1,0,1, "R10 error again");
        s(1,0, 1,0,1,0,1, "R10 no new sequence started");
        s(0,1, 0,0,0,0,0, "R6 read clears");
        fast_req = 1'b0;
        s(0,0, 0,0,0,0,0, "R10 bit cleared");
        fast_req = 1'b1;
        s(1,0, 1,0,1,0,0, "R10 fresh request accepted");
        s(1,0, 1,0,1,1,0, "R10 fresh sequence steers to temperature");
        s(0,1, 0,0,0,1,0, "R8 voltage read");
        s(1,0, 0,1,1,0,0, "R8 temperature flagged");
        fast_req = 1'b0;
        s(0,1, 0,0,0,0,0, "R6 read clears");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule